// File: doc/BRIEF.md
# Switchable Power Domain Policy Controller

This block manages one switchable power domain. Software picks a policy: a static policy holds the domain in a chosen power state whatever the activity. A dynamic policy lets the domain fall to a programmed floor state whenever its internal devices agree to go quiescent, and brings it back to ON when an enabled wake source asks for it. The block drives the power-switch, retention, isolation and domain-reset controls in a fixed order. It talks to the devices inside the domain through Q-Channel requester handshakes.

There are four power states. A low state (OFF, retention or warm reset) is always entered from ON and always left towards ON. A policy write that arrives while a transition is in flight is held back. It takes effect once the domain has settled. A wake request that arrives while the domain is powering down abandons the descent at the next safe step. Which of the four wake sources may wake the domain, and whether retention keeps the logic state or only the memories, are fixed by parameters for each domain. A domain with no enabled wake sources only makes sense under static policy.

Top module: `pwr_domain_ctrl`

## Requirements
- R1: After reset the domain is ON: `psw_on`=1, `ret_en`=0, `iso_en`=0, `dom_rst_n`=1, every `qreq_n` bit is 1, `stat_state`=3 and `stat_busy`=0. The active policy is static ON.
- R2: State codes on `cfg_state` and `stat_state` are 0=OFF, 1=RET, 2=warm reset, 3=ON. With `cfg_dyn`=0 the domain settles in the written state, and wake requests have no effect on it.
- R3: `stat_state` only moves from ON to a low state or from a low state to ON. It never moves directly between two low states.
- R4: With `cfg_dyn`=1 the written state is a floor. With no enabled wake pending and all devices accepting, the domain settles in the floor state. A floor of ON keeps it ON.
- R5: A descent first drives all `qreq_n` low. It proceeds only once every `qaccept_n` bit is low and no `qdeny` bit is high. Any `qdeny` high aborts the descent, and the domain stays ON.
- R6: `wake_req` bits are: 0 access gate, 1 debug power-up, 2 external wakeup controller, 3 expansion Q-Channel. Only bits set in parameter WAKE_EN count. Under dynamic policy an enabled bit returns a low domain to ON, and a disabled bit has no effect.
- R7: Going down, `iso_en` rises one cycle before `psw_on` falls (OFF, RET) or before `dom_rst_n` falls (warm reset). `ret_en` rises only with `iso_en` already high.
- R8: Going up, `psw_on` rises first, and `dom_rst_n` stays low until `psw_ack` is seen. `iso_en` falls one cycle after `dom_rst_n` rises, and `qreq_n` goes high with it. The domain is reported ON once all `qaccept_n` are high and all `qdeny` are low.
- R9: In RET, `ret_en`=1 and `psw_on`=0. With RET_FULL=0 (memory-only retention) `dom_rst_n` is low in RET. With RET_FULL=1 it stays high.
- R10: A policy write while `stat_busy`=1 does not change the ongoing transition. It is applied once the domain reaches a settled state, and the last such write wins.
- R11: Under dynamic policy, an enabled wake arriving during a descent returns the domain to ON without `psw_on` ever falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Policy write strobe |
| cfg_dyn | input | 1 | 1 = dynamic policy, 0 = static |
| cfg_state | input | 2 | Static target or dynamic floor state code |
| stat_state | output | 2 | Current settled power state code |
| stat_busy | output | 1 | Transition in progress |
| wake_req | input | 4 | Wake requests, one bit per source |
| qreq_n | output | NUM_DEV | Q-Channel quiescence requests, active low |
| qaccept_n | input | NUM_DEV | Q-Channel accepts, active low |
| qdeny | input | NUM_DEV | Q-Channel denials |
| psw_on | output | 1 | Power switch enable |
| psw_ack | input | 1 | Power switch on acknowledge |
| ret_en | output | 1 | Retention enable |
| iso_en | output | 1 | Output isolation enable |
| dom_rst_n | output | 1 | Domain reset, active low |

## Verification
Directed cases cover the following:
- Static entry into each low state, which separates the isolate-then-cut order from the reversed power-up order.
- An acknowledge held off, which shows that the reset waits for the switch.
- A device that denies, which separates an aborted descent from a completed one.
- Masked versus enabled wake bits, which shows the per-domain mask at work.
- A wake injected while isolation is up, which shows the mid-descent abort.
- Back-to-back policy writes, which show the deferred write.

Random rounds mix policy kind, state code, wake bits and device denial, and compare the settled state and control pins with a bench model of the policy.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    P_OFF  = 2'd0,
    P_RET  = 2'd1,
    P_WRST = 2'd2,
    P_ON   = 2'd3
  } pwr_t;

  typedef enum logic [2:0] {
    SQ_ON, SQ_QREQ, SQ_ISO, SQ_LOW, SQ_PUP, SQ_REL, SQ_QEXIT
  } seq_t;

  localparam int NUM_WAKE = 4;
endpackage

// File: rtl/pdc_policy.sv
module pdc_policy
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_dyn,
  input  pwr_t cfg_state,
  input  logic busy,
  output logic act_dyn,
  output pwr_t act_state
);
  logic pend_vld;
  logic pend_dyn;
  pwr_t pend_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_dyn    <= 1'b0;
      act_state  <= P_ON;
      pend_vld   <= 1'b0;
      pend_dyn   <= 1'b0;
      pend_state <= P_ON;
    end else if (cfg_we) begin
      if (busy) begin
        pend_vld   <= 1'b1;
        pend_dyn   <= cfg_dyn;
        pend_state <= cfg_state;
      end else begin
        act_dyn   <= cfg_dyn;
        act_state <= cfg_state;
        pend_vld  <= 1'b0;
      end
    end else if (pend_vld && !busy) begin
      act_dyn   <= pend_dyn;
      act_state <= pend_state;
      pend_vld  <= 1'b0;
    end
  end
endmodule

// File: rtl/pdc_wake.sv
module pdc_wake
  import pdc_pkg::*;
#(
  parameter logic [NUM_WAKE-1:0] WAKE_EN = 4'b1101
) (
  input  logic [NUM_WAKE-1:0] wake_req,
  output logic                wake_any
);
  logic [NUM_WAKE-1:0] masked;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_src
    if (WAKE_EN[i]) begin : g_on
      assign masked[i] = wake_req[i];
    end else begin : g_off
      assign masked[i] = 1'b0;
    end
  end

  assign wake_any = |masked;
endmodule

// File: rtl/pdc_qch.sv
module pdc_qch #(
  parameter int NUM_DEV = 2
) (
  input  logic               req_low,
  output logic [NUM_DEV-1:0] qreq_n,
  input  logic [NUM_DEV-1:0] qaccept_n,
  input  logic [NUM_DEV-1:0] qdeny,
  output logic               all_acc,
  output logic               any_deny,
  output logic               all_run
);
  logic [NUM_DEV-1:0] dev_run;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    assign qreq_n[d]  = ~req_low;
    assign dev_run[d] = qaccept_n[d] & ~qdeny[d];
  end

  assign all_acc  = ~|qaccept_n;
  assign any_deny = |qdeny;
  assign all_run  = &dev_run;
endmodule

// File: rtl/pdc_seq.sv
module pdc_seq
  import pdc_pkg::*;
#(
  parameter bit RET_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_dyn,
  input  pwr_t act_state,
  input  logic wake_any,
  input  logic all_acc,
  input  logic any_deny,
  input  logic all_run,
  input  logic psw_ack,
  output logic req_low,
  output logic iso_en,
  output logic ret_en,
  output logic psw_on,
  output logic dom_rst_n,
  output pwr_t stat_state,
  output logic busy
);
  seq_t sq, sq_n;
  pwr_t low_tgt, low_tgt_n;
  pwr_t pstate, pstate_n;
  pwr_t goal;
  logic keep_logic;

  assign goal = (act_dyn && wake_any) ? P_ON : act_state;
  assign keep_logic = RET_FULL && (low_tgt == P_RET);

  always_comb begin
    sq_n      = sq;
    low_tgt_n = low_tgt;
    pstate_n  = pstate;
    unique case (sq)
      SQ_ON: if (goal != P_ON) begin
        sq_n      = SQ_QREQ;
        low_tgt_n = goal;
      end
      SQ_QREQ: begin
        if (any_deny || goal == P_ON) sq_n = SQ_QEXIT;
        else if (all_acc)             sq_n = SQ_ISO;
      end
      SQ_ISO: begin
        if (goal == P_ON) sq_n = SQ_QEXIT;
        else begin
          sq_n     = SQ_LOW;
          pstate_n = low_tgt;
        end
      end
      SQ_LOW:   if (goal != low_tgt) sq_n = SQ_PUP;
      SQ_PUP:   if (psw_ack) sq_n = SQ_REL;
      SQ_REL:   sq_n = SQ_QEXIT;
      SQ_QEXIT: if (all_run) begin
        sq_n     = SQ_ON;
        pstate_n = P_ON;
      end
      default:  sq_n = SQ_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq      <= SQ_ON;
      low_tgt <= P_ON;
      pstate  <= P_ON;
    end else begin
      sq      <= sq_n;
      low_tgt <= low_tgt_n;
      pstate  <= pstate_n;
    end
  end

  always_comb begin
    req_low   = 1'b0;
    iso_en    = 1'b0;
    ret_en    = 1'b0;
    psw_on    = 1'b1;
    dom_rst_n = 1'b1;
    unique case (sq)
      SQ_QREQ: req_low = 1'b1;
      SQ_ISO: begin
        req_low = 1'b1;
        iso_en  = 1'b1;
      end
      SQ_LOW: begin
        req_low   = 1'b1;
        iso_en    = 1'b1;
        psw_on    = (low_tgt == P_WRST);
        ret_en    = (low_tgt == P_RET);
        dom_rst_n = keep_logic;
      end
      SQ_PUP: begin
        req_low   = 1'b1;
        iso_en    = 1'b1;
        ret_en    = (low_tgt == P_RET);
        dom_rst_n = keep_logic;
      end
      SQ_REL: begin
        req_low = 1'b1;
        iso_en  = 1'b1;
      end
      default: ;
    endcase
  end

  assign stat_state = pstate;
  assign busy       = (sq != SQ_ON) && (sq != SQ_LOW);
endmodule

// File: rtl/pwr_domain_ctrl.sv
module pwr_domain_ctrl
  import pdc_pkg::*;
#(
  parameter int                  NUM_DEV  = 2,
  parameter logic [NUM_WAKE-1:0] WAKE_EN  = 4'b1101,
  parameter bit                  RET_FULL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_dyn,
  input  logic [1:0]          cfg_state,
  output logic [1:0]          stat_state,
  output logic                stat_busy,
  input  logic [NUM_WAKE-1:0] wake_req,
  output logic [NUM_DEV-1:0]  qreq_n,
  input  logic [NUM_DEV-1:0]  qaccept_n,
  input  logic [NUM_DEV-1:0]  qdeny,
  output logic                psw_on,
  input  logic                psw_ack,
  output logic                ret_en,
  output logic                iso_en,
  output logic                dom_rst_n
);
  logic act_dyn;
  pwr_t act_state;
  logic wake_any;
  logic req_low, all_acc, any_deny, all_run;
  pwr_t pstate;

  pdc_policy u_policy (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_dyn   (cfg_dyn),
    .cfg_state (pwr_t'(cfg_state)),
    .busy      (stat_busy),
    .act_dyn   (act_dyn),
    .act_state (act_state)
  );

  pdc_wake #(.WAKE_EN(WAKE_EN)) u_wake (
    .wake_req (wake_req),
    .wake_any (wake_any)
  );

  pdc_qch #(.NUM_DEV(NUM_DEV)) u_qch (
    .req_low   (req_low),
    .qreq_n    (qreq_n),
    .qaccept_n (qaccept_n),
    .qdeny     (qdeny),
    .all_acc   (all_acc),
    .any_deny  (any_deny),
    .all_run   (all_run)
  );

  pdc_seq #(.RET_FULL(RET_FULL)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_dyn    (act_dyn),
    .act_state  (act_state),
    .wake_any   (wake_any),
    .all_acc    (all_acc),
    .any_deny   (any_deny),
    .all_run    (all_run),
    .psw_ack    (psw_ack),
    .req_low    (req_low),
    .iso_en     (iso_en),
    .ret_en     (ret_en),
    .psw_on     (psw_on),
    .dom_rst_n  (dom_rst_n),
    .stat_state (pstate),
    .busy       (stat_busy)
  );

  assign stat_state = pstate;
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int NUM_DEV  = 2,
  parameter bit RET_FULL = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DEV-1:0] qreq_n,
  input logic [NUM_DEV-1:0] qaccept_n,
  input logic [NUM_DEV-1:0] qdeny,
  input logic               psw_on,
  input logic               psw_ack,
  input logic               ret_en,
  input logic               iso_en,
  input logic               dom_rst_n,
  input logic [1:0]         stat_state
);
  AST_LOW_STATE_VIA_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_state) |-> (stat_state == 2'd3 || $past(stat_state) == 2'd3)); // R3

  AST_ISO_AFTER_ALL_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> ($past(qaccept_n) == '0 && $past(qdeny) == '0 && $past(~|qreq_n))); // R5

  AST_SWITCH_OFF_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psw_on) |-> $past(iso_en)); // R7

  AST_RESET_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dom_rst_n) |-> $past(iso_en)); // R7

  AST_RET_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    ret_en |-> iso_en); // R7

  AST_RESET_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_on && !psw_ack && !(RET_FULL && stat_state == 2'd1)) |-> !dom_rst_n); // R8

  AST_ISO_DROP_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (psw_on && dom_rst_n && !ret_en && $past(dom_rst_n))); // R8

  AST_QREQ_RAISE_UNISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&qreq_n) |-> !iso_en); // R8
endmodule

bind pwr_domain_ctrl pdc_checker #(.NUM_DEV(NUM_DEV), .RET_FULL(RET_FULL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .qreq_n     (qreq_n),
  .qaccept_n  (qaccept_n),
  .qdeny      (qdeny),
  .psw_on     (psw_on),
  .psw_ack    (psw_ack),
  .ret_en     (ret_en),
  .iso_en     (iso_en),
  .dom_rst_n  (dom_rst_n),
  .stat_state (stat_state)
);

// File: tb/tb_pwr_domain_ctrl.sv
module tb_pwr_domain_ctrl;
  localparam int         NDEV   = 2;
  localparam logic [3:0] WMASK  = 4'b1101;
  localparam bit         RFULL  = 1'b0;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_dyn;
  logic [1:0] cfg_state, stat_state;
  logic stat_busy;
  logic [3:0] wake_req;
  logic [NDEV-1:0] qreq_n, qaccept_n, qdeny;
  logic psw_on, psw_ack, ret_en, iso_en, dom_rst_n;
  logic deny_mode, ack_hold;
  int total = 0, bad = 0;
  int illegal_moves = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_domain_ctrl #(.NUM_DEV(NDEV), .WAKE_EN(WMASK), .RET_FULL(RFULL)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dyn(cfg_dyn), .cfg_state(cfg_state),
    .stat_state(stat_state), .stat_busy(stat_busy), .wake_req(wake_req),
    .qreq_n(qreq_n), .qaccept_n(qaccept_n), .qdeny(qdeny),
    .psw_on(psw_on), .psw_ack(psw_ack), .ret_en(ret_en), .iso_en(iso_en), .dom_rst_n(dom_rst_n)
  );

  // Q-Channel device models and power-switch model
  for (genvar d = 0; d < NDEV; d++) begin : g_devm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        qaccept_n[d] <= 1'b1;
        qdeny[d]     <= 1'b0;
      end else if (qreq_n[d]) begin
        qaccept_n[d] <= 1'b1;
        qdeny[d]     <= 1'b0;
      end else if (qaccept_n[d] && !qdeny[d]) begin
        if (deny_mode) qdeny[d] <= 1'b1;
        else           qaccept_n[d] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psw_ack <= 1'b1;
    else        psw_ack <= psw_on & ~ack_hold;
  end

  // R3 monitor on reported state
  logic [1:0] prev_state;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stat_state != prev_state && stat_state != 2'd3 && prev_state != 2'd3)
        illegal_moves++;
    end
    prev_state <= stat_state;
  end

  function automatic logic [1:0] exp_state(logic dyn, logic [1:0] st, logic [3:0] wk, logic dn);
    if (dyn && ((wk & WMASK) != 4'd0)) return 2'd3;
    if (dn) return 2'd3;
    return st;
  endfunction

  // {psw_on, ret_en, iso_en, dom_rst_n}
  function automatic logic [3:0] exp_pins(logic [1:0] s);
    case (s)
      2'd0:    return 4'b0010;
      2'd1:    return {3'b011, RFULL};
      2'd2:    return 4'b1010;
      default: return 4'b1001;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic dyn, input logic [1:0] st);
    @(negedge clk);
    cfg_we = 1'b1; cfg_dyn = dyn; cfg_state = st;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] pins();
    return {psw_on, ret_en, iso_en, dom_rst_n};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int iso_up, psw_dn, rst_up, iso_dn;
    bit psw_fell, iso_rose, seen_off;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_dyn = 1'b0; cfg_state = 2'd3;
    wake_req = 4'd0; deny_mode = 1'b0; ack_hold = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(pins() == 4'b1001, "R1 pins", pins(), 4'b1001);
    chk(stat_state == 2'd3 && !stat_busy, "R1 state", {stat_busy, stat_state}, 3);
    chk(qreq_n == '1, "R1 qreq_n", qreq_n, 3);

    // R7 power-down order into OFF
    wr(1'b0, 2'd0);
    iso_up = -1; psw_dn = -1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (iso_en && iso_up < 0) iso_up = c;
      if (!psw_on && psw_dn < 0) psw_dn = c;
    end
    chk(iso_up >= 0 && psw_dn == iso_up + 1, "R7 iso then switch", psw_dn, iso_up + 1);
    chk(stat_state == 2'd0 && pins() == exp_pins(2'd0), "R2 static OFF", pins(), exp_pins(2'd0));

    // R2 static ignores wakes
    wake_req = 4'b1111;
    settle(20);
    chk(stat_state == 2'd0, "R2 wake ignored in static", stat_state, 0);
    wake_req = 4'd0;

    // R8 power-up order with held acknowledge
    ack_hold = 1'b1;
    wr(1'b0, 2'd3);
    settle(8);
    chk(psw_on && !dom_rst_n && iso_en, "R8 reset held until ack", pins(), 4'b1010);
    chk(qreq_n == '0, "R8 qreq held low", qreq_n, 0);
    ack_hold = 1'b0;
    rst_up = -1; iso_dn = -1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (dom_rst_n && rst_up < 0) rst_up = c;
      if (!iso_en && iso_dn < 0) begin
        iso_dn = c;
        chk(qreq_n == '1, "R8 qreq raised with iso drop", qreq_n, 3);
      end
    end
    chk(rst_up >= 0 && iso_dn == rst_up + 1, "R8 reset then iso", iso_dn, rst_up + 1);
    chk(stat_state == 2'd3 && pins() == 4'b1001, "R8 back ON", stat_state, 3);

    // R9 memory-only retention
    wr(1'b0, 2'd1);
    settle(20);
    chk(stat_state == 2'd1 && pins() == exp_pins(2'd1), "R9 retention pins", pins(), exp_pins(2'd1));
    wr(1'b0, 2'd3);
    settle(20);

    // R10 deferred policy write
    wr(1'b0, 2'd0);
    @(negedge clk);
    chk(stat_busy, "R10 busy during descent", stat_busy, 1);
    cfg_we = 1'b1; cfg_dyn = 1'b0; cfg_state = 2'd1;
    @(negedge clk) cfg_we = 1'b0;
    seen_off = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (stat_state == 2'd0) seen_off = 1'b1;
    end
    chk(seen_off, "R10 first transition completed", seen_off, 1);
    chk(stat_state == 2'd1, "R10 pending applied", stat_state, 1);
    wr(1'b0, 2'd3);
    settle(20);

    // R4 dynamic floors
    wr(1'b1, 2'd2);
    settle(20);
    chk(stat_state == 2'd2 && pins() == exp_pins(2'd2), "R4 floor warm reset", pins(), exp_pins(2'd2));
    wr(1'b1, 2'd3);
    settle(20);
    chk(stat_state == 2'd3 && !stat_busy, "R4 floor ON", stat_state, 3);

    // R6 wake mask
    wr(1'b1, 2'd0);
    settle(20);
    chk(stat_state == 2'd0, "R6 dynamic down", stat_state, 0);
    wake_req = 4'b0010;
    settle(20);
    chk(stat_state == 2'd0 && !psw_on, "R6 masked debug wake ignored", stat_state, 0);
    wake_req = 4'b1000;
    settle(20);
    chk(stat_state == 2'd3 && pins() == 4'b1001, "R6 expansion wake", stat_state, 3);
    wake_req = 4'd0;
    settle(20);
    chk(stat_state == 2'd0, "R6 down again", stat_state, 0);
    wake_req = 4'b0001;
    settle(20);
    chk(stat_state == 2'd3, "R6 access gate wake", stat_state, 3);
    wake_req = 4'd0;
    wr(1'b0, 2'd3);
    settle(20);

    // R5 device denial
    deny_mode = 1'b1;
    wr(1'b1, 2'd0);
    psw_fell = 1'b0; iso_rose = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (!psw_on) psw_fell = 1'b1;
      if (iso_en) iso_rose = 1'b1;
    end
    chk(!psw_fell && !iso_rose && stat_state == 2'd3, "R5 deny keeps ON", {psw_fell, iso_rose}, 0);
    wr(1'b0, 2'd3);
    deny_mode = 1'b0;
    settle(20);

    // R11 wake during descent
    wr(1'b1, 2'd0);
    psw_fell = 1'b0; iso_rose = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (iso_en && !iso_rose) begin
        iso_rose = 1'b1;
        wake_req = 4'b0100;
      end
      if (!psw_on) psw_fell = 1'b1;
    end
    chk(iso_rose && !psw_fell, "R11 abort before switch off", psw_fell, 0);
    chk(stat_state == 2'd3 && pins() == 4'b1001, "R11 ON after abort", stat_state, 3);
    wake_req = 4'd0;
    wr(1'b0, 2'd3);
    settle(20);

    // Random rounds (R2, R4, R6)
    void'($urandom(32'd1234));
    for (int i = 0; i < 30; i++) begin
      logic dyn; logic [1:0] st; logic [3:0] wk; logic dn; logic [1:0] e;
      dyn = 1'($urandom); st = 2'($urandom); wk = 4'($urandom);
      dn  = ($urandom % 4) == 0;
      if ($urandom % 2) wk = 4'd0;
      wr(1'b0, 2'd3);
      settle(20);
      deny_mode = dn; wake_req = wk;
      wr(dyn, st);
      settle(30);
      e = exp_state(dyn, st, wk, dn);
      chk(stat_state == e, dyn ? "R4 R6 random state" : "R2 random state", stat_state, e);
      if (!dn)
        chk(pins() == exp_pins(e), "R2 R4 random pins", pins(), exp_pins(e));
      deny_mode = 1'b0; wake_req = 4'd0;
    end

    chk(illegal_moves == 0, "R3 only via ON", illegal_moves, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule